// File: doc/BRIEF.md
# Dual-Bank Ratio Clock Divider

This block models the output divider stage of a clock driver in synchronous form. One fast master clock stands in for the oscillator. The block derives three single-ended output clocks from it, all registered in the master clock domain: a feedback clock, a bank-A clock and a bank-B clock. The feedback clock always runs at the reference rate. The bank-A clock runs at one of four fractional ratios of that rate. The bank-B clock copies either bank A or the feedback clock. A synchronisation pulse marks each cycle in which the rising edges of bank A and the feedback clock coincide.

A small state machine controls the block. It has three states:
- **ARM** is entered from reset and from bypass exit. It captures the ratio and bank selects, then starts both dividers on a shared phase origin.
- **RUN** is normal division.
- **BYP** is the static test mode. Every output clock toggles on every master cycle.

The transitions are:
- ARM→RUN when bypass is low.
- ARM→BYP and RUN→BYP when bypass is high.
- BYP→BYP while bypass stays high.
- BYP→ARM when bypass falls.
- Asynchronous reset to ARM from any state.

With the scale parameter S, each ratio code sets a feedback half-period of Nfb·S master cycles and a bank-A half-period of Na·S master cycles. The pairs (Nfb, Na) are:

| Ratio code | QA:QFB | Nfb | Na |
|---|---|---|---|
| 00 | 1:1 | 1 | 1 |
| 01 | 1:2 | 1 | 2 |
| 10 | 3:4 | 3 | 4 |
| 11 | 4:5 | 4 | 5 |

The two clocks realign every P = 2·Nfb·Na·S master cycles.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: While rst_ni is low, all four outputs are 0. After release, the first clock edge (ARM) leaves the outputs at 0. qfb_o and qa_o then both rise together at the second clock edge after release.
- R2: In RUN, qfb_o is an exact 50% clock with a half-period of Nfb·S master cycles. The feedback half-period units Nfb are 1, 1, 3 and 4 for ratio codes 00, 01, 10 and 11. qfb_o is never gated by out_en_i.
- R3: In RUN, qa_o is an exact 50% clock with a half-period of Na·S master cycles. The bank-A units Na are 1, 2, 4 and 5 for codes 00, 01, 10 and 11. This gives QA:QFB frequency ratios of 1:1, 1:2, 3:4 and 4:5.
- R4: Within one realignment period P = 2·Nfb·Na·S, qfb_o rises Na times and qa_o rises Nfb times. Their rising edges coincide at the start of every period.
- R5: With bank_sel_i = 0, qb_o equals qa_o. With bank_sel_i = 1, qb_o follows qfb_o but is still gated by out_en_i.
- R6: When out_en_i is 0 before an edge, qa_o, qb_o and sync_o are 0 after that edge, while qfb_o keeps toggling.
- R7: For every ratio code except 00, sync_o is high for one full qfb_o period. It rises at the qfb_o falling edge that precedes a coincident rising edge and falls at the next qfb_o falling edge. After release, the first pulse is shortened: it starts at the first coincident edge. For code 00, sync_o stays 0.
- R8: While bypass_i is high, the block is in BYP. Entry drives all internal clocks low. After that they toggle together every master cycle, and sync_o stays 0.
- R9: The selects are captured only in ARM. When bypass_i falls, BYP goes to ARM and then RUN: the outputs are 0 one edge later and qfb_o and qa_o rise together the edge after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, stands in for the oscillator |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| ratio_sel_i | input | 2 | QA:QFB ratio code, captured in ARM |
| bank_sel_i | input | 1 | 0: bank B follows bank A; 1: bank B follows the feedback clock |
| out_en_i | input | 1 | Output enable for bank A, bank B and sync; active high |
| bypass_i | input | 1 | Static test mode: all clocks toggle every master cycle |
| qfb_o | output | 1 | Feedback clock |
| qa_o | output | 1 | Bank-A clock |
| qb_o | output | 1 | Bank-B clock |
| sync_o | output | 1 | Coincidence marker pulse |

## Verification
The bench drops out_en_i in the cycle where sync_o is high just before a coincident rising edge. This makes the gating and the sync pulse land on the same edge. The behavioural model then requires sync_o and qa_o to fall while qfb_o keeps its scheduled rise. The bench also compares bypass entry and exit against the model edge by edge, because entry can coincide with a divider toggle and exit restarts the shared phase origin.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_ARM = 2'd0,
        ST_RUN = 2'd1,
        ST_BYP = 2'd2
    } dd_state_e;

    typedef struct packed {
        logic [1:0] ratio;
        logic       bank;
    } dd_cfg_t;

    // feedback half-period in units of the scale parameter
    function automatic int unsigned fb_units(input logic [1:0] code);
        int unsigned u;
        unique case (code)
            2'b00:   u = 1;
            2'b01:   u = 1;
            2'b10:   u = 3;
            default: u = 4;
        endcase
        return u;
    endfunction

    // bank-A half-period in units of the scale parameter
    function automatic int unsigned a_units(input logic [1:0] code);
        int unsigned u;
        unique case (code)
            2'b00:   u = 1;
            2'b01:   u = 2;
            2'b10:   u = 4;
            default: u = 5;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/dd_half_div.sv
module dd_half_div #(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          clr_lvl_i,
    input  logic          fast_i,
    input  logic          run_i,
    input  logic [CW-1:0] half_i,
    output logic          q_o
);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == half_i - 1'b1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            q_o   <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= '0;
            q_o   <= clr_lvl_i;
        end else if (fast_i) begin
            cnt_q <= '0;
            q_o   <= ~q_o;
        end else if (run_i) begin
            if (wrap) begin
                cnt_q <= '0;
                q_o   <= ~q_o;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // half-period counter never passes its limit while dividing
    assert_cnt_below_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q < half_i));

    // level holds between toggle points, giving exact 50% duty
    assert_hold_between_toggles_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !clr_i && !fast_i && (cnt_q != half_i - 1'b1)) |=> $stable(q_o));

endmodule

// File: rtl/dd_phase_track.sv
module dd_phase_track #(
    parameter int PW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          run_i,
    input  logic          sync_en_i,
    input  logic [PW-1:0] period_i,
    input  logic [PW-1:0] lead_i,
    output logic          sync_o
);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] ph_n;
    logic          in_window;

    always_comb begin
        ph_n      = (ph_q == period_i - 1'b1) ? '0 : ph_q + 1'b1;
        in_window = (ph_n >= period_i - lead_i) || (ph_n < lead_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_q   <= '0;
            sync_o <= 1'b0;
        end else if (start_i) begin
            ph_q   <= '0;
            sync_o <= sync_en_i;
        end else if (run_i) begin
            ph_q   <= ph_n;
            sync_o <= sync_en_i && in_window;
        end else begin
            ph_q   <= '0;
            sync_o <= 1'b0;
        end
    end

    assert_phase_below_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (ph_q < period_i));

    assert_no_sync_unity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !sync_en_i) |=> !sync_o);

endmodule

// File: rtl/dual_bank_clkdiv.sv
module dual_bank_clkdiv
    import clkdiv_pkg::*;
#(
    parameter int SCALE = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] ratio_sel_i,
    input  logic       bank_sel_i,
    input  logic       out_en_i,
    input  logic       bypass_i,
    output logic       qfb_o,
    output logic       qa_o,
    output logic       qb_o,
    output logic       sync_o
);

    localparam int HMAX = 5 * SCALE;
    localparam int CW   = $clog2(HMAX + 1);
    localparam int PMAX = 40 * SCALE;
    localparam int PW   = $clog2(PMAX + 1);

    dd_state_e     state_q, state_d;
    dd_cfg_t       cfg_q, live_cfg, eff_cfg;
    logic [CW-1:0] half_fb, half_a;
    logic [PW-1:0] period, lead;
    logic [CW-1:0] half_arr [2];
    logic [1:0]    div_q;
    logic          sync_q;
    logic          div_clr, div_lvl, div_fast, div_run;
    logic          ph_start, ph_run;

    // configuration: live in ARM, held afterwards
    assign live_cfg = '{ratio: ratio_sel_i, bank: bank_sel_i};
    assign eff_cfg  = (state_q == ST_ARM) ? live_cfg : cfg_q;

    always_comb begin
        half_fb = CW'(fb_units(eff_cfg.ratio) * SCALE);
        half_a  = CW'(a_units(eff_cfg.ratio) * SCALE);
        period  = PW'(2 * fb_units(eff_cfg.ratio) * a_units(eff_cfg.ratio) * SCALE);
        lead    = PW'(fb_units(eff_cfg.ratio) * SCALE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (state_q == ST_ARM) begin
            cfg_q <= live_cfg;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM:  state_d = bypass_i ? ST_BYP : ST_RUN;
            ST_RUN:  state_d = bypass_i ? ST_BYP : ST_RUN;
            ST_BYP:  state_d = bypass_i ? ST_BYP : ST_ARM;
            default: state_d = ST_ARM;
        endcase
    end

    // per-state controls
    always_comb begin
        div_clr  = 1'b0;
        div_lvl  = 1'b0;
        div_fast = 1'b0;
        div_run  = 1'b0;
        ph_start = 1'b0;
        ph_run   = 1'b0;
        unique case (state_q)
            ST_ARM: begin
                div_clr  = 1'b1;
                div_lvl  = !bypass_i;
                ph_start = !bypass_i;
            end
            ST_RUN: begin
                div_clr  = bypass_i;
                div_run  = !bypass_i;
                ph_run   = !bypass_i;
            end
            ST_BYP: begin
                div_fast = bypass_i;
                div_clr  = !bypass_i;
            end
            default: div_clr = 1'b1;
        endcase
    end

    assign half_arr[0] = half_fb;
    assign half_arr[1] = half_a;

    for (genvar g = 0; g < 2; g++) begin : g_div
        dd_half_div #(.CW(CW)) u_div (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .clr_i     (div_clr),
            .clr_lvl_i (div_lvl),
            .fast_i    (div_fast),
            .run_i     (div_run),
            .half_i    (half_arr[g]),
            .q_o       (div_q[g])
        );
    end

    dd_phase_track #(.PW(PW)) u_phase (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (ph_start),
        .run_i     (ph_run),
        .sync_en_i (eff_cfg.ratio != 2'b00),
        .period_i  (period),
        .lead_i    (lead),
        .sync_o    (sync_q)
    );

    // output register stage with enable gating (feedback never gated)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            qfb_o  <= 1'b0;
            qa_o   <= 1'b0;
            qb_o   <= 1'b0;
            sync_o <= 1'b0;
        end else begin
            qfb_o  <= div_q[0];
            qa_o   <= div_q[1] & out_en_i;
            qb_o   <= (eff_cfg.bank ? div_q[0] : div_q[1]) & out_en_i;
            sync_o <= sync_q & out_en_i;
        end
    end

    assert_oe_gates_banks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_en_i |=> (!qa_o && !qb_o && !sync_o));

    assert_bypass_toggles_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BYP && bypass_i) |=> (div_q[0] != $past(div_q[0])));

    assert_arm_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ARM && !bypass_i) |=> (state_q == ST_RUN));

    assert_byp_exit_rearms_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BYP && !bypass_i) |=> (state_q == ST_ARM));

endmodule

// File: tb/sim_dual_bank_clkdiv.sv
`timescale 1ns/1ps
module sim_dual_bank_clkdiv;

    localparam int S = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ratio_sel = 2'b00;
    logic       bank_sel = 1'b0;
    logic       oe = 1'b1;
    logic       bypass = 1'b0;
    logic       qfb, qa, qb, sync;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_st = 0;
    int ifb = 0, ia = 0, isync = 0, ip = 0, cfb = 0, ca = 0;
    int m_ratio = 0, m_bank = 0;
    int e_qfb = 0, e_qa = 0, e_qb = 0, e_sync = 0;

    always #4 clk = ~clk;

    dual_bank_clkdiv #(.SCALE(S)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ratio_sel_i (ratio_sel),
        .bank_sel_i  (bank_sel),
        .out_en_i    (oe),
        .bypass_i    (bypass),
        .qfb_o       (qfb),
        .qa_o        (qa),
        .qb_o        (qb),
        .sync_o      (sync)
    );

    function automatic int ufb(input int r);
        case (r)
            0: return 1;
            1: return 1;
            2: return 3;
            default: return 4;
        endcase
    endfunction

    function automatic int uaa(input int r);
        case (r)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 5;
        endcase
    endfunction

    // behavioural reference, advanced once per rising edge
    always @(posedge clk) begin
        int er, eb, hf, ha, per, oldfb;
        if (!rst_n) begin
            m_st = 0; ifb = 0; ia = 0; isync = 0; ip = 0; cfb = 0; ca = 0;
            m_ratio = 0; m_bank = 0;
            e_qfb = 0; e_qa = 0; e_qb = 0; e_sync = 0;
        end else begin
            er = (m_st == 0) ? int'(ratio_sel) : m_ratio;
            eb = (m_st == 0) ? int'(bank_sel) : m_bank;
            e_qfb  = ifb;
            e_qa   = ia & int'(oe);
            e_qb   = (eb != 0 ? ifb : ia) & int'(oe);
            e_sync = isync & int'(oe);
            hf  = ufb(er) * S;
            ha  = uaa(er) * S;
            per = 2 * ufb(er) * uaa(er) * S;
            if (m_st == 0) begin
                m_ratio = er; m_bank = eb;
                if (bypass) begin
                    m_st = 2; ifb = 0; ia = 0; isync = 0; ip = 0; cfb = 0; ca = 0;
                end else begin
                    m_st = 1; ifb = 1; ia = 1; ip = 0; cfb = 0; ca = 0;
                    isync = (er != 0) ? 1 : 0;
                end
            end else if (m_st == 1) begin
                if (bypass) begin
                    m_st = 2; ifb = 0; ia = 0; isync = 0; ip = 0; cfb = 0; ca = 0;
                end else begin
                    if (cfb == hf - 1) begin cfb = 0; ifb = 1 - ifb; end else cfb++;
                    if (ca == ha - 1) begin ca = 0; ia = 1 - ia; end else ca++;
                    ip = (ip + 1) % per;
                    isync = (er != 0 && (ip >= per - hf || ip < hf)) ? 1 : 0;
                end
            end else begin
                if (bypass) begin
                    oldfb = ifb; ifb = 1 - oldfb; ia = ifb;
                end else begin
                    m_st = 0; ifb = 0; ia = 0; isync = 0; ip = 0; cfb = 0; ca = 0;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one master cycle, then compare all outputs with the model
    task automatic cyc();
        @(negedge clk);
        chk("R2", "qfb_o model", int'(qfb), e_qfb);
        chk("R3", "qa_o model", int'(qa), e_qa);
        chk("R5", "qb_o model", int'(qb), e_qb);
        chk("R7", "sync_o model", int'(sync), e_sync);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int per, hf, rf, ra, rb, rs, hfc, hac, hs, pf, pa, pb, ps;
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            rst_n = 1'b0; oe = 1'b1; bypass = 1'b0;
            ratio_sel = 2'(r); bank_sel = r[0];
            cyc(); cyc(); cyc();
            chk("R1", "outputs in reset", int'({qfb, qa, qb, sync}), 0);
            rst_n = 1'b1;
            cyc();
            chk("R1", "qfb_o after arm edge", int'(qfb), 0);
            cyc();
            chk("R1", "qfb_o&qa_o first rise", int'(qfb & qa), 1);
            per = 2 * ufb(r) * uaa(r) * S;
            hf  = ufb(r) * S;
            rf = 1; ra = 1; rb = 1; rs = int'(sync);
            hfc = 1; hac = 1; hs = int'(sync);
            pf = 1; pa = 1; pb = int'(qb); ps = int'(sync);
            for (int k = 1; k < per; k++) begin
                cyc();
                if (qfb && pf == 0) rf++;
                if (qa && pa == 0) ra++;
                if (qb && pb == 0) rb++;
                if (sync && ps == 0) rs++;
                hfc += int'(qfb); hac += int'(qa); hs += int'(sync);
                pf = int'(qfb); pa = int'(qa); pb = int'(qb); ps = int'(sync);
            end
            chk("R4", "qfb_o rises per period", rf, uaa(r));
            chk("R3", "qa_o rises per period", ra, ufb(r));
            chk("R2", "qfb_o high cycles", hfc, per / 2);
            chk("R3", "qa_o high cycles", hac, per / 2);
            chk("R5", "qb_o rises per period", rb, (r % 2 == 1) ? uaa(r) : ufb(r));
            chk("R7", "sync_o high cycles", hs, (r != 0) ? 2 * hf : 0);
            chk("R7", "sync_o rises", rs, (r != 0) ? 2 : 0);
            for (int k = 0; k < per; k++) cyc();
            if (r == 3) begin
                // drop enable while the sync pulse is active before realignment
                chk("R7", "sync_o before enable drop", int'(sync), 1);
                oe = 1'b0;
                rf = 0; hac = 0; pf = int'(qfb);
                for (int k = 0; k < 12; k++) begin
                    cyc();
                    if (qfb != pf[0]) rf++;
                    hac += int'(qa) + int'(qb) + int'(sync);
                    pf = int'(qfb);
                end
                chk("R6", "qfb_o toggles while disabled", int'(rf > 0), 1);
                chk("R6", "gated outputs high count", hac, 0);
                oe = 1'b1;
                for (int k = 0; k < 5; k++) cyc();
                bypass = 1'b1;
                cyc(); cyc(); cyc();
                rf = 0; hs = 0; pf = int'(qfb);
                for (int k = 0; k < 6; k++) begin
                    cyc();
                    if (qfb != pf[0]) rf++;
                    if (qa != qfb) hs++;
                    hs += int'(sync);
                    pf = int'(qfb);
                end
                chk("R8", "bypass toggle count", rf, 6);
                chk("R8", "bypass qa/qfb mismatch or sync", hs, 0);
                bypass = 1'b0;
                cyc();
                cyc();
                chk("R9", "outputs after re-arm edge", int'(qfb | qa), 0);
                cyc();
                chk("R9", "qfb_o&qa_o rise after re-arm", int'(qfb & qa), 1);
                for (int k = 0; k < 2 * per; k++) cyc();
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule